// File: doc/BRIEF.md
# Load/Store-Multiple Transfer Sequencer

This block carries out a block data transfer between a run of registers and word memory. A start strobe hands it a base address, a 16-bit register mask, a direction bit (count up or down), an index mode bit (update the address before or after each access), a load/store bit and a write-back bit. The block then serves one register per set mask bit, one memory word per register. For each word it raises a request on a memory port and waits until memory reports completion. On a store it sends the register value fetched through its register-file read port. On a load it writes the returned word into the register through its register-file write port.

Counting up, the registers are served from the lowest set bit upward, and the running address grows by 4 per word. Counting down, they are served from the highest set bit downward, and the address shrinks by 4. When the mask is used up the block raises a one-cycle finish pulse. If write-back was requested, it offers the final running address as the new base value in that same cycle. Instruction decode, the register-file storage and the cache sit outside the block.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o`, `done_o`, `rf_we_o` and `base_we_o` are all 0.
- R2: A start with an all-zero `reg_list_i` raises no memory request. It pulses `done_o` in the cycle after the start and raises no `base_we_o`.
- R3: When `dir_up_i`=1 the registers are served in ascending index order (lowest remaining set bit first). When `dir_up_i`=0 they are served in descending order. `rf_idx_o` carries the 4-bit index of the register being served, and mask bit i stands for register i.
- R4: The running address starts at `base_addr_i`. Each served word changes it to the address ±4 (+4 when counting up). With `pre_idx_i`=1 the access uses the changed address. With `pre_idx_i`=0 it uses the address before the change.
- R5: `mem_addr_o[1:0]` is always 0 while `mem_req_o` is high, whatever the alignment of the base.
- R6: While `mem_req_o` is high and `mem_done_i` is low, the request, its address and the register index stay unchanged into the next cycle.
- R7: On a load (`is_load_i`=1), `mem_we_o`=0. In the cycle where `mem_done_i` is high, `rf_we_o`=1 and `rf_wdata_o`=`mem_rdata_i`. On a store, `mem_we_o`=1, `mem_wdata_o`=`rf_rdata_i` and `rf_we_o` stays 0.
- R8: `busy_o` is high from the cycle after an accepted start through the cycle of the `done_o` pulse, and is low in the cycle after it. `done_o` lasts exactly one cycle and follows the last completed word.
- R9: With `wb_en_i`=1, `base_we_o` is high together with `done_o`, and `base_val_o` holds the final running address (base ±4·count, unaligned bits kept). With `wb_en_i`=0, `base_we_o` stays 0.
- R10: The operands are captured at the start. A start strobe or a change of operands while busy has no effect, and `mem_done_i` has no effect while no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| base_addr_i | input | 32 | Starting base address |
| reg_list_i | input | 16 | Register mask, bit i = register i |
| dir_up_i | input | 1 | 1: addresses rise, ascending order; 0: fall, descending |
| pre_idx_i | input | 1 | 1: change the address before each access; 0: after |
| is_load_i | input | 1 | 1: load into registers; 0: store from registers |
| wb_en_i | input | 1 | Write the final address back as the new base |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle finish pulse |
| mem_req_o | output | 1 | Memory word request valid |
| mem_we_o | output | 1 | 1: write request, 0: read request |
| mem_addr_o | output | 32 | Word-aligned request address |
| mem_wdata_o | output | 32 | Write data |
| mem_done_i | input | 1 | Memory completes the current request |
| mem_rdata_i | input | 32 | Read data, valid with mem_done_i |
| rf_idx_o | output | 4 | Index of the register being served |
| rf_rdata_i | input | 32 | Value of register rf_idx_o (for stores) |
| rf_we_o | output | 1 | Register write strobe (loads) |
| rf_wdata_o | output | 32 | Register write data |
| base_we_o | output | 1 | Base register write strobe |
| base_val_o | output | 32 | New base value |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives while a sequence is still waiting on memory, with a full mask and a different base on the operand inputs. If the block accepted it, the order, addresses and final base would all quietly change. The bench holds memory completion back by a configurable number of cycles so that the sequencer stays in its stall. It fires the intruding strobe mid-sequence, and the scoreboard then checks that every following word still matches the operands captured at the original start. Completion pulses sent while nothing is requested are checked in the same way at the register and base strobes.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_XFER   = 2'd1,
    SEQ_FINISH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bx_prio_enc.sv
// Priority encoder over the remaining mask. LOW_FIRST picks the lowest set
// bit, otherwise the highest one.
module bx_prio_enc #(
  parameter int N         = 16,
  parameter bit LOW_FIRST = 1'b1,
  localparam int IW       = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  generate
    if (LOW_FIRST) begin : g_low
      always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
          if (vec_i[i]) idx_o = IW'(i);
        end
      end
    end else begin : g_high
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
          if (vec_i[i]) idx_o = IW'(i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bx_addr_step.sv
// Address arithmetic: next running address and the aligned access address.
module bx_addr_step #(
  parameter int ADDR_W     = 32,
  parameter int STEP       = 4,
  parameter int ALIGN_BITS = 2
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              up_i,
  input  logic              pre_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic [ADDR_W-1:0] acc_o
);
  function automatic logic [ADDR_W-1:0] step_fn(input logic [ADDR_W-1:0] a,
                                                input logic up);
    return up ? a + ADDR_W'(STEP) : a - ADDR_W'(STEP);
  endfunction

  function automatic logic [ADDR_W-1:0] align_fn(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << ALIGN_BITS;
    return a & m;
  endfunction

  assign nxt_o = step_fn(cur_i, up_i);
  assign acc_o = align_fn(pre_i ? nxt_o : cur_i);
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NREGS      = 16,
  parameter int STEP       = 4,
  parameter int ALIGN_BITS = 2,
  localparam int IW        = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [NREGS-1:0]  reg_list_i,
  input  logic              dir_up_i,
  input  logic              pre_idx_i,
  input  logic              is_load_i,
  input  logic              wb_en_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_done_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [IW-1:0]     rf_idx_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              base_we_o,
  output logic [ADDR_W-1:0] base_val_o
);
  seq_state_e        state_q;
  logic [NREGS-1:0]  list_q;
  logic [ADDR_W-1:0] addr_q;
  logic              up_q, pre_q, ld_q, wb_q, some_q;

  // Named internal events
  logic              accept_start;
  logic              word_done;
  logic              last_word;
  logic [IW-1:0]     lo_idx, hi_idx, sel_idx;
  logic [NREGS-1:0]  list_left;
  logic [ADDR_W-1:0] addr_nxt, addr_acc;

  bx_prio_enc #(.N(NREGS), .LOW_FIRST(1'b1)) u_lo (.vec_i(list_q), .idx_o(lo_idx));
  bx_prio_enc #(.N(NREGS), .LOW_FIRST(1'b0)) u_hi (.vec_i(list_q), .idx_o(hi_idx));

  bx_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP), .ALIGN_BITS(ALIGN_BITS)) u_step (
    .cur_i(addr_q), .up_i(up_q), .pre_i(pre_q), .nxt_o(addr_nxt), .acc_o(addr_acc)
  );

  assign sel_idx      = up_q ? lo_idx : hi_idx;
  assign list_left    = list_q & ~(NREGS'(1) << sel_idx);
  assign last_word    = (list_left == '0);
  assign accept_start = (state_q == SEQ_IDLE) && start_i;
  assign word_done    = (state_q == SEQ_XFER) && mem_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      list_q  <= '0;
      addr_q  <= '0;
      up_q    <= 1'b0;
      pre_q   <= 1'b0;
      ld_q    <= 1'b0;
      wb_q    <= 1'b0;
      some_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (accept_start) begin
          list_q  <= reg_list_i;
          addr_q  <= base_addr_i;
          up_q    <= dir_up_i;
          pre_q   <= pre_idx_i;
          ld_q    <= is_load_i;
          wb_q    <= wb_en_i;
          some_q  <= |reg_list_i;
          state_q <= (|reg_list_i) ? SEQ_XFER : SEQ_FINISH;
        end
        SEQ_XFER: if (word_done) begin
          list_q <= list_left;
          addr_q <= addr_nxt;
          if (last_word) state_q <= SEQ_FINISH;
        end
        SEQ_FINISH: state_q <= SEQ_IDLE;
        default:    state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != SEQ_IDLE);
  assign done_o      = (state_q == SEQ_FINISH);
  assign mem_req_o   = (state_q == SEQ_XFER);
  assign mem_we_o    = mem_req_o && !ld_q;
  assign mem_addr_o  = mem_req_o ? addr_acc : '0;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_idx_o    = sel_idx;
  assign rf_we_o     = word_done && ld_q;
  assign rf_wdata_o  = mem_rdata_i;
  assign base_we_o   = done_o && wb_q && some_q;
  assign base_val_o  = addr_q;
endmodule

// File: rtl/bx_seq_checker.sv
module bx_seq_checker #(
  parameter int ADDR_W = 32,
  parameter int NREGS  = 16,
  parameter int IW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [NREGS-1:0]  reg_list_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_done_i,
  input logic [IW-1:0]     rf_idx_o,
  input logic              rf_we_o,
  input logic              base_we_o
);
  assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !done_o && !rf_we_o && !base_we_o);

  assert_empty_list_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && reg_list_i == '0) |=> (done_o && !mem_req_o));

  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_done_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(rf_idx_o) && $stable(mem_we_o)));

  assert_load_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_req_o && mem_done_i && !mem_we_o));

  assert_finish_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  assert_base_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    base_we_o |-> done_o);
endmodule

bind blkxfer_seq bx_seq_checker #(.ADDR_W(ADDR_W), .NREGS(NREGS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_list_i(reg_list_i),
  .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_done_i(mem_done_i), .rf_idx_o(rf_idx_o),
  .rf_we_o(rf_we_o), .base_we_o(base_we_o)
);

// File: tb/test_blkxfer_seq.sv
`timescale 1ns/1ps
module test_blkxfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [15:0] reg_list_i = '0;
  logic        dir_up_i = 1'b0, pre_idx_i = 1'b0, is_load_i = 1'b0, wb_en_i = 1'b0;
  logic        busy_o, done_o, mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_done_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [3:0]  rf_idx_o;
  logic [31:0] rf_rdata_i;
  logic        rf_we_o;
  logic [31:0] rf_wdata_o;
  logic        base_we_o;
  logic [31:0] base_val_o;

  always #5 clk = ~clk;

  blkxfer_seq i_blkxfer_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .reg_list_i(reg_list_i), .dir_up_i(dir_up_i), .pre_idx_i(pre_idx_i),
    .is_load_i(is_load_i), .wb_en_i(wb_en_i), .busy_o(busy_o), .done_o(done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_done_i(mem_done_i), .mem_rdata_i(mem_rdata_i),
    .rf_idx_o(rf_idx_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_wdata_o(rf_wdata_o), .base_we_o(base_we_o), .base_val_o(base_val_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int resp_delay = 0;
  int wait_cnt   = 0;
  bit spurious   = 1'b0;
  int seen_words = 0;

  typedef struct {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  idx;
  } exp_t;
  exp_t exp_q[$];

  function automatic logic [31:0] reg_model(input logic [3:0] i);
    return 32'hC0DE_0000 + 32'(i) * 32'h0000_0101;
  endfunction
  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C3C_0000;
  endfunction

  assign rf_rdata_i = reg_model(rf_idx_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Memory responder and scoreboard monitor
  always @(negedge clk) begin
    mem_done_i = 1'b0;
    if (rst_n && mem_req_o) begin
      if (wait_cnt >= resp_delay) begin
        wait_cnt    = 0;
        mem_done_i  = 1'b1;
        mem_rdata_i = mem_model(mem_addr_o);
        #1;
        seen_words++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", {28'd0, rf_idx_o}, 32'hFFFF_FFFF, "unexpected transfer");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rf_idx_o == e.idx, "R3", {28'd0, rf_idx_o}, {28'd0, e.idx}, "register order");
          chk(mem_addr_o == e.addr, "R4", mem_addr_o, e.addr, "access address");
          chk(mem_addr_o[1:0] == 2'b00, "R5", mem_addr_o, e.addr, "alignment");
          chk(mem_we_o == e.we, "R7", {31'd0, mem_we_o}, {31'd0, e.we}, "direction");
          if (e.we) begin
            chk(mem_wdata_o == reg_model(e.idx), "R7", mem_wdata_o, reg_model(e.idx), "store data");
            chk(rf_we_o == 1'b0, "R7", {31'd0, rf_we_o}, 32'd0, "no rf write on store");
          end else begin
            chk(rf_we_o == 1'b1, "R7", {31'd0, rf_we_o}, 32'd1, "rf write on load");
            chk(rf_wdata_o == mem_model(e.addr), "R7", rf_wdata_o, mem_model(e.addr), "load data");
          end
        end
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
      if (rst_n && spurious) begin
        mem_done_i = 1'b1;
        #1;
        chk(!rf_we_o && !base_we_o && !busy_o, "R10",
            {29'd0, rf_we_o, base_we_o, busy_o}, 32'd0, "done while idle");
      end
    end
  end

  // Driver: push expectations, start, wait for finish, check base.
  task automatic run_op(input logic [31:0] base, input logic [15:0] list,
                        input bit up, input bit pre, input bit ld, input bit wb,
                        input int dly, input bit poke);
    logic [31:0] cur, nxt;
    int cnt = 0;
    int guard = 0;
    resp_delay = dly;
    seen_words = 0;
    cur = base;
    for (int k = 0; k < 16; k++) begin
      int r = up ? k : 15 - k;
      if (list[r]) begin
        exp_t e;
        nxt    = up ? cur + 32'd4 : cur - 32'd4;
        e.we   = !ld;
        e.addr = (pre ? nxt : cur) & 32'hFFFF_FFFC;
        e.idx  = 4'(r);
        exp_q.push_back(e);
        cur = nxt;
        cnt++;
      end
    end
    @(negedge clk);
    base_addr_i = base; reg_list_i = list; dir_up_i = up; pre_idx_i = pre;
    is_load_i = ld; wb_en_i = wb; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8", {31'd0, busy_o}, 32'd1, "busy after start");
    if (poke) begin
      base_addr_i = 32'hDEAD_0000; reg_list_i = 16'hFFFF; dir_up_i = !up;
      pre_idx_i = !pre; is_load_i = !ld; wb_en_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    #2;
    chk(done_o == 1'b1, "R8", {31'd0, done_o}, 32'd1, "finish reached");
    if (cnt == 0)
      chk(guard == 0, "R2", 32'(guard), 32'd0, "empty list finishes next cycle");
    chk(seen_words == cnt, "R3", 32'(seen_words), 32'(cnt), "transfer count");
    chk(exp_q.size() == 0, "R3", 32'(exp_q.size()), 32'd0, "scoreboard drained");
    if (wb && cnt != 0) begin
      chk(base_we_o == 1'b1, "R9", {31'd0, base_we_o}, 32'd1, "base write strobe");
      chk(base_val_o == cur, "R9", base_val_o, cur, "final base value");
    end else begin
      chk(base_we_o == 1'b0, "R9", {31'd0, base_we_o}, 32'd0, "no base write");
    end
    exp_q.delete();
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R8", {30'd0, busy_o, done_o}, 32'd0,
        "idle after finish");
  endtask

  initial begin
    #1000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy_o && !mem_req_o && !done_o && !rf_we_o && !base_we_o, "R1",
        {27'd0, busy_o, mem_req_o, done_o, rf_we_o, base_we_o}, 32'd0, "reset state");
    rst_n = 1'b1;
    // R2: empty list
    run_op(32'h0000_1000, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    // R3/R4 four direction/index combinations, single-bit lists
    run_op(32'h0000_2000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run_op(32'h0000_2000, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b1, 1, 1'b0);
    run_op(32'h0000_2000, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1'b0);
    run_op(32'h0000_2000, 16'h0400, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b0);
    // full lists, all four combinations
    run_op(32'h0000_3000, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run_op(32'h0000_3000, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1, 1'b0);
    run_op(32'h0000_3000, 16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, 2, 1'b0);
    run_op(32'h0000_3000, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b0);
    // R5: unaligned base, sparse lists; R9 without write-back
    run_op(32'h0000_4003, 16'hA5C3, 1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0);
    run_op(32'h0000_4002, 16'h4182, 1'b0, 1'b0, 1'b1, 1'b0, 0, 1'b0);
    // address wrap when counting down from zero
    run_op(32'h0000_0000, 16'h0007, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    // R10: start strobe and operand changes while busy, long stall (R6)
    run_op(32'h0000_5000, 16'h0906, 1'b1, 1'b0, 1'b0, 1'b1, 3, 1'b1);
    // R10: completion pulses with no request outstanding
    spurious = 1'b1;
    repeat (4) @(negedge clk);
    spurious = 1'b0;
    @(negedge clk);
    run_op(32'h0000_6000, 16'h0101, 1'b0, 1'b1, 1'b1, 1'b1, 1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule